// File: doc/BRIEF.md
# Program Counter and Instruction Fetch Unit

This unit keeps the program counter of a single-cycle processor and presents, in the same cycle, the instruction word stored at that address. At every clock edge the counter advances to the next sequential word, or, when the decoder marks the current instruction as a conditional branch and the datapath reports that the two compared registers are equal, to a target relative to the sequential address.

The target is the sequential address (PC + 4) plus the 16-bit immediate, sign-extended and scaled by four. It is built by a dedicated extender and adder, separate from the main ALU. The instructions come from a small word-addressed memory inside the unit. A synchronous write port fills that memory before the processor runs, and can patch a word while it runs. All address arithmetic wraps modulo 2^32.

Top module: `ifu_fetch_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc_o` is 0x00000000 after that edge.
- R2: When `br_sel` is low, the next `pc_o` is the current `pc_o` + 4.
- R3: When `br_sel` and `br_eq` are both high, the next `pc_o` is the current `pc_o` + 4 + (sign-extended `br_imm` × 4).
- R4: When `br_sel` is high and `br_eq` is low, the branch falls through and the next `pc_o` is the current `pc_o` + 4.
- R5: A high `br_eq` with `br_sel` low has no effect on the next `pc_o`, which is the current `pc_o` + 4.
- R6: A negative immediate moves the counter backwards, and `br_imm` = 0xFFFF on a taken branch leaves `pc_o` unchanged (a self-loop).
- R7: `instr_o` is, in the same cycle, the memory word at index `pc_o[IDX_W+1:2]`, where IDX_W = log2(depth). Higher address bits are ignored, so the index wraps modulo the depth.
- R8: When `wr_en` is high at a rising edge, `wr_data` is stored at word index `wr_addr`. The new word is visible on `instr_o` from that edge on. Writes take effect whether or not `rst` is high.
- R9: `pc_o[1:0]` is always 00.
- R10: Address arithmetic wraps modulo 2^32. From 0x00000000, a taken branch with `br_imm` = 0xFFFE gives 0xFFFFFFFC, and the sequential step from 0xFFFFFFFC gives 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| br_sel | input | 1 | Current instruction is a conditional branch |
| br_eq | input | 1 | Compared registers are equal |
| br_imm | input | 16 | Signed word offset of the branch |
| wr_en | input | 1 | Instruction memory write enable |
| wr_addr | input | IDX_W (6) | Word index to write |
| wr_data | input | 32 | Word to write |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction at `pc_o` |

## Verification
A branch decision presented in a cycle shows up on `pc_o` one edge later. `instr_o` follows `pc_o` with no added delay, and a memory write becomes visible one edge after it is issued. The bench drives inputs on the falling edge. It samples both outputs on the next falling edge, where it compares them with a model that applies the inputs driven half a cycle before the intervening rising edge. Directed sequences cover the self-loop, the backward branch, the address wrap and a reset during a run. Seeded random branches and memory writes cover the rest.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned IMM_W     = 16;
  localparam int unsigned WORD_SHFT = 2;

  typedef logic [XLEN-1:0] addr_t;

  typedef enum logic {
    NPC_SEQ    = 1'b0,
    NPC_BRANCH = 1'b1
  } npc_src_e;
endpackage

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
  import ifu_pkg::*;
#(
  parameter int unsigned AW = XLEN,
  parameter int unsigned IW = IMM_W
) (
  input  logic [AW-1:0] pc_cur,
  input  logic          br_sel,
  input  logic          br_eq,
  input  logic [IW-1:0] br_imm,
  output logic [AW-1:0] pc_nxt
);
  localparam int unsigned EXT_W = AW - IW - WORD_SHFT;

  npc_src_e      src;
  logic [AW-1:0] seq_addr;
  logic [AW-1:0] br_offs;
  logic [AW-1:0] br_addr;

  // Branch offset: sign-extend and scale by word size
  generate
    if (EXT_W > 0) begin : g_ext
      assign br_offs = {{EXT_W{br_imm[IW-1]}}, br_imm, {WORD_SHFT{1'b0}}};
    end else begin : g_trunc
      logic [IW+WORD_SHFT-1:0] wide;
      assign wide    = {br_imm, {WORD_SHFT{1'b0}}};
      assign br_offs = wide[AW-1:0];
    end
  endgenerate

  assign seq_addr = pc_cur + AW'(4);
  assign br_addr  = seq_addr + br_offs;
  assign src      = (br_sel && br_eq) ? NPC_BRANCH : NPC_SEQ;

  always_comb begin
    unique case (src)
      NPC_BRANCH: pc_nxt = br_addr;
      default:    pc_nxt = seq_addr;
    endcase
  end
endmodule

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg
  import ifu_pkg::*;
#(
  parameter int unsigned AW = XLEN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] pc_nxt,
  output logic [AW-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assert_reset_pc_R1: assert property (@(posedge clk) rst |=> (pc_q == '0));
endmodule

// File: rtl/ifu_imem.sv
module ifu_imem #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ifu_fetch_unit.sv
module ifu_fetch_unit
  import ifu_pkg::*;
#(
  parameter int unsigned AW    = XLEN,
  parameter int unsigned DW    = 32,
  parameter int unsigned IW    = IMM_W,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_sel,
  input  logic             br_eq,
  input  logic [IW-1:0]    br_imm,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [AW-1:0]    pc_o,
  output logic [DW-1:0]    instr_o
);
  logic [AW-1:0] pc_nxt;

  ifu_next_pc #(.AW(AW), .IW(IW)) u_next (
    .pc_cur (pc_o),
    .br_sel (br_sel),
    .br_eq  (br_eq),
    .br_imm (br_imm),
    .pc_nxt (pc_nxt)
  );

  ifu_pc_reg #(.AW(AW)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .pc_nxt (pc_nxt),
    .pc_q   (pc_o)
  );

  ifu_imem #(.DW(DW), .DEPTH(DEPTH)) u_imem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (pc_o[IDX_W+WORD_SHFT-1:WORD_SHFT]),
    .rd_data (instr_o)
  );

  assert_seq_R2: assert property (@(posedge clk) disable iff (rst)
    !br_sel |=> (pc_o == $past(pc_o) + AW'(4)));

  assert_taken_R3: assert property (@(posedge clk) disable iff (rst)
    (br_sel && br_eq) |=>
      (pc_o == $past(pc_o) + AW'(4) + (AW'($signed($past(br_imm))) << WORD_SHFT)));

  assert_fallthru_R4: assert property (@(posedge clk) disable iff (rst)
    (br_sel && !br_eq) |=> (pc_o == $past(pc_o) + AW'(4)));

  assert_selfloop_R6: assert property (@(posedge clk) disable iff (rst)
    (br_sel && br_eq && (br_imm == '1)) |=> $stable(pc_o));

  assert_align_R9: assert property (@(posedge clk) disable iff (rst)
    pc_o[1:0] == 2'b00);
endmodule

// File: tb/ifu_fetch_unit_tb.sv
module ifu_fetch_unit_tb;
  localparam int DEPTH = 64;
  localparam int IDX_W = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             br_sel = 1'b0;
  logic             br_eq = 1'b0;
  logic [15:0]      br_imm = '0;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_addr = '0;
  logic [31:0]      wr_data = '0;
  logic [31:0]      pc_o;
  logic [31:0]      instr_o;

  logic [31:0] model [DEPTH];
  logic [31:0] exp_pc;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ifu_fetch_unit u_dut (
    .clk(clk), .rst(rst), .br_sel(br_sel), .br_eq(br_eq), .br_imm(br_imm),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pc_o(pc_o), .instr_o(instr_o)
  );

  function automatic logic [31:0] next_pc(input logic [31:0] pc, input logic s,
                                          input logic e, input logic [15:0] imm);
    logic [31:0] off;
    off = {{14{imm[15]}}, imm, 2'b00};
    return (s && e) ? pc + 32'd4 + off : pc + 32'd4;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic check_out(input string tag);
    check({tag, " pc"}, pc_o, exp_pc);
    check("R7 instr", instr_o, model[exp_pc[IDX_W+1:2]]);
    check("R9 align", {30'd0, pc_o[1:0]}, 32'd0);
  endtask

  // Drive one cycle of branch inputs at the falling edge, then check at the next
  task automatic step(input logic s, input logic e, input logic [15:0] imm, input string tag);
    br_sel = s; br_eq = e; br_imm = imm;
    if (rst) exp_pc = 32'd0;
    else     exp_pc = next_pc(exp_pc, s, e, imm);
    if (wr_en) model[wr_addr] = wr_data;
    @(negedge clk);
    check_out(tag);
  endtask

  initial begin
    void'($urandom(32'd12345));
    @(negedge clk);
    // Fill memory during reset (R8: writes work while rst is high)
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 1'b1; wr_addr = IDX_W'(i); wr_data = $urandom;
      step(1'b0, 1'b0, 16'h0, "R1 reset");
    end
    wr_en = 1'b0;
    check("R1 reset value", pc_o, 32'd0);
    rst = 1'b0;

    step(1'b0, 1'b0, 16'h0010, "R2 seq");
    step(1'b0, 1'b0, 16'h0000, "R2 seq");
    step(1'b0, 1'b1, 16'h0100, "R5 eq-only");
    step(1'b1, 1'b0, 16'h0100, "R4 fallthru");
    step(1'b1, 1'b1, 16'h0003, "R3 forward");
    step(1'b1, 1'b1, 16'hFFFD, "R6 backward");
    step(1'b1, 1'b1, 16'hFFFF, "R6 selfloop");
    step(1'b1, 1'b1, 16'hFFFF, "R6 selfloop");
    check("R6 selfloop held", pc_o, exp_pc);

    // Patch the word currently fetched; visible after the edge (R8)
    wr_en = 1'b1; wr_addr = pc_o[IDX_W+1:2]; wr_data = 32'hC0DE_F00D;
    step(1'b1, 1'b1, 16'hFFFF, "R8 write");
    wr_en = 1'b0;
    check("R8 patched word", instr_o, 32'hC0DE_F00D);

    // Reset mid-run, then address wrap (R10)
    rst = 1'b1;
    step(1'b0, 1'b0, 16'h0, "R1 midrun");
    check("R1 midrun zero", pc_o, 32'd0);
    rst = 1'b0;
    step(1'b1, 1'b1, 16'hFFFE, "R10 wrap down");
    check("R10 wrap value", pc_o, 32'hFFFF_FFFC);
    check("R7 top index", instr_o, model[DEPTH-1]);
    step(1'b0, 1'b0, 16'h0, "R10 wrap up");
    check("R10 wrap zero", pc_o, 32'd0);

    // Seeded random phase
    for (int k = 0; k < 400; k++) begin
      wr_en   = ($urandom % 4) == 0;
      wr_addr = IDX_W'($urandom);
      wr_data = $urandom;
      step(1'($urandom), 1'($urandom), 16'($urandom), "R3 random");
    end
    wr_en = 1'b0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule